// File: doc/BRIEF.md
# Packed Float Compare Mask Unit

This block compares a 128-bit destination operand against a 128-bit source operand as four separate IEEE-754 single-precision values and turns each comparison into a lane-wide bit mask. The low three bits of an 8-bit immediate select one of eight predicates. These cover the ordered relations (equal, less-than, less-or-equal), their negations, and the ordered and unordered tests. Because the result is a mask and not a flag, software can use it directly with bitwise select operations.

A scalar select limits the compare to the lowest lane. The upper three lanes of the result then copy the destination operand. The result is registered. It appears one clock after an input strobe, together with a one-cycle valid flag.

Top module: `packed_fcmp_mask`

## Requirements
- R1: `imm_i[2:0]` selects the predicate: 0 equal, 1 less-than, 2 less-or-equal, 3 unordered, 4 not-equal, 5 not-less-than, 6 not-less-or-equal, 7 ordered.
- R2: Lane k occupies bits `32k+31 : 32k` of each operand and of the result, for k = 0..3. Every lane is compared on its own with the same predicate.
- R3: A lane whose predicate holds is written as 0xFFFFFFFF. Any other lane is written as 0x00000000.
- R4: When `scalar_i` is 1, only lane 0 is compared, and result bits 127:32 equal bits 127:32 of `dst_i`.
- R5: A value is NaN when its exponent bits 30:23 are all ones and its mantissa bits 22:0 are nonzero. A pair with a NaN on either side is unordered. For such a pair, equal, less-than, less-or-equal and ordered are false, while not-equal, not-less-than, not-less-or-equal and unordered are true.
- R6: +0.0 and -0.0 compare as equal, and neither is less than the other.
- R7: `imm_i[7:3]` has no effect on the result.
- R8: `res_o` takes the new result at the first rising edge after `in_valid` is sampled high. `res_valid_o` is high for exactly the cycles following sampled strobes. `res_o` holds its value while no strobe arrives.
- R9: A synchronous reset `rst` clears `res_o` and `res_valid_o` to zero and overrides a strobe in the same cycle.
- R10: Non-NaN values are ordered by their real value. Negative values sort below positive ones, infinities lie at the ends, and denormals sort by their magnitude.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands and controls are valid this cycle |
| dst_i | input | 128 | Destination operand, four single-precision lanes |
| src_i | input | 128 | Source operand, four single-precision lanes |
| imm_i | input | 8 | Predicate select; only bits 2:0 are used |
| scalar_i | input | 1 | 1: compare lane 0 only; 0: compare all lanes |
| res_o | output | 128 | Registered mask result |
| res_valid_o | output | 1 | One-cycle pulse when `res_o` is updated |

## Verification
The per-lane relation state is the equal, less-than and unordered decision for each lane. A wrong value there shows up in the very next result word as a mask of the wrong polarity in that lane. Exchanging the NaN test, the sign handling or the zero rule therefore flips specific lanes for specific value pairs one cycle after the strobe. A fault in the scalar merge or in the hold path shows up as upper lanes that differ from the destination operand, or as a result that changes with no strobe.

// File: rtl/fcmp_pkg.sv
package fcmp_pkg;

  typedef enum logic [2:0] {
    PR_EQ    = 3'd0,
    PR_LT    = 3'd1,
    PR_LE    = 3'd2,
    PR_UNORD = 3'd3,
    PR_NEQ   = 3'd4,
    PR_NLT   = 3'd5,
    PR_NLE   = 3'd6,
    PR_ORD   = 3'd7
  } pred_e;

  // Relation of one lane pair; eq and lt are already forced low when unordered.
  typedef struct packed {
    logic unord;
    logic eq;
    logic lt;
  } lane_rel_t;

  function automatic logic pred_eval(input lane_rel_t rel, input pred_e pred);
    logic hit;
    case (pred)
      PR_EQ:    hit = rel.eq;
      PR_LT:    hit = rel.lt;
      PR_LE:    hit = rel.lt | rel.eq;
      PR_UNORD: hit = rel.unord;
      PR_NEQ:   hit = ~rel.eq;
      PR_NLT:   hit = ~rel.lt;
      PR_NLE:   hit = ~(rel.lt | rel.eq);
      default:  hit = ~rel.unord;
    endcase
    return hit;
  endfunction

endpackage

// File: rtl/fcmp_rel.sv
module fcmp_rel
  import fcmp_pkg::*;
#(
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic [EXP_W+MAN_W:0] a_i,
  input  logic [EXP_W+MAN_W:0] b_i,
  output lane_rel_t            rel_o
);
  localparam int W     = 1 + EXP_W + MAN_W;
  localparam int MAG_W = W - 1;

  function automatic logic is_nan(input logic [W-1:0] x);
    return (&x[W-2:MAN_W]) && (|x[MAN_W-1:0]);
  endfunction

  // Sign-magnitude ordering of two non-NaN values.
  function automatic logic mag_less(input logic [W-1:0] a, input logic [W-1:0] b,
                                    input logic both_zero);
    logic less;
    if (a[W-1] != b[W-1])   less = a[W-1] & ~both_zero;
    else if (!a[W-1])       less = a[MAG_W-1:0] < b[MAG_W-1:0];
    else                    less = a[MAG_W-1:0] > b[MAG_W-1:0];
    return less;
  endfunction

  logic nan_a, nan_b, both_zero, unord;

  always_comb begin
    nan_a     = is_nan(a_i);
    nan_b     = is_nan(b_i);
    unord     = nan_a | nan_b;
    both_zero = (a_i[MAG_W-1:0] == '0) && (b_i[MAG_W-1:0] == '0);
    rel_o.unord = unord;
    rel_o.eq    = ~unord & ((a_i == b_i) | both_zero);
    rel_o.lt    = ~unord & mag_less(a_i, b_i, both_zero);
  end

endmodule

// File: rtl/fcmp_mask.sv
module fcmp_mask
  import fcmp_pkg::*;
#(
  parameter int LANE_W = 32
) (
  input  lane_rel_t          rel_i,
  input  pred_e              pred_i,
  output logic [LANE_W-1:0]  mask_o
);
  always_comb mask_o = {LANE_W{pred_eval(rel_i, pred_i)}};
endmodule

// File: rtl/packed_fcmp_mask.sv
module packed_fcmp_mask
  import fcmp_pkg::*;
#(
  parameter int LANES = 4,
  parameter int EXP_W = 8,
  parameter int MAN_W = 23
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                in_valid,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0]    dst_i,
  input  logic [LANES*(1+EXP_W+MAN_W)-1:0]    src_i,
  input  logic [7:0]                          imm_i,
  input  logic                                scalar_i,
  output logic [LANES*(1+EXP_W+MAN_W)-1:0]    res_o,
  output logic                                res_valid_o
);
  localparam int LANE_W = 1 + EXP_W + MAN_W;
  localparam int VEC_W  = LANES * LANE_W;

  pred_e     pred;
  lane_rel_t lane_rel [LANES];
  logic [LANES-1:0][LANE_W-1:0] lane_mask;
  logic [VEC_W-1:0] next_res;

  assign pred = pred_e'(imm_i[2:0]);

  for (genvar k = 0; k < LANES; k++) begin : g_lane
    fcmp_rel #(.EXP_W(EXP_W), .MAN_W(MAN_W)) u_rel (
      .a_i   (dst_i[k*LANE_W +: LANE_W]),
      .b_i   (src_i[k*LANE_W +: LANE_W]),
      .rel_o (lane_rel[k])
    );
    fcmp_mask #(.LANE_W(LANE_W)) u_mask (
      .rel_i  (lane_rel[k]),
      .pred_i (pred),
      .mask_o (lane_mask[k])
    );
    if (k == 0) begin : g_low
      assign next_res[LANE_W-1:0] = lane_mask[0];
    end else begin : g_high
      assign next_res[k*LANE_W +: LANE_W] =
        scalar_i ? dst_i[k*LANE_W +: LANE_W] : lane_mask[k];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      res_o       <= '0;
      res_valid_o <= 1'b0;
    end else begin
      res_valid_o <= in_valid;
      if (in_valid) res_o <= next_res;
    end
  end

  // R8: valid flag tracks the strobe with one cycle of latency
  a_r8_valid_follows: assert property (@(posedge clk) disable iff (rst)
    in_valid |=> res_valid_o);
  a_r8_valid_drops: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> !res_valid_o);
  a_r8_hold: assert property (@(posedge clk) disable iff (rst)
    !in_valid |=> $stable(res_o));

  // R4: scalar mode passes destination upper lanes through
  a_r4_scalar_upper: assert property (@(posedge clk) disable iff (rst)
    (in_valid && scalar_i) |=> res_o[VEC_W-1:LANE_W] == $past(dst_i[VEC_W-1:LANE_W]));

  // R3: lane 0 is always a full mask of one polarity
  a_r3_lane0_mask: assert property (@(posedge clk) disable iff (rst)
    res_valid_o |-> (res_o[LANE_W-1:0] == '0 || res_o[LANE_W-1:0] == '1));

  // R5: unordered pair forces the ordered-type predicates false, the rest true
  a_r5_unord_false: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_rel[0].unord && !imm_i[2] && imm_i[1:0] != 2'd3)
      |=> res_o[LANE_W-1:0] == '0);
  a_r5_unord_true: assert property (@(posedge clk) disable iff (rst)
    (in_valid && lane_rel[0].unord && imm_i[2] && imm_i[1:0] != 2'd3)
      |=> res_o[LANE_W-1:0] == '1);

  // R6/R10: relation decisions are mutually exclusive
  a_r10_rel_exclusive: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> $countones({lane_rel[0].eq, lane_rel[0].lt, lane_rel[0].unord}) <= 1);

  // R1: equal predicate on an equal pair yields all ones
  a_r1_eq_hit: assert property (@(posedge clk) disable iff (rst)
    (in_valid && pred == PR_EQ && lane_rel[0].eq) |=> res_o[LANE_W-1:0] == '1);

endmodule

// File: tb/tb_packed_fcmp_mask.sv
module tb_packed_fcmp_mask;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic [127:0] dst_i = '0;
  logic [127:0] src_i = '0;
  logic [7:0]   imm_i = '0;
  logic         scalar_i = 1'b0;
  logic [127:0] res_o;
  logic         res_valid_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  localparam int NV = 13;

  always #2.5 clk = ~clk;

  packed_fcmp_mask dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .dst_i(dst_i), .src_i(src_i),
    .imm_i(imm_i), .scalar_i(scalar_i), .res_o(res_o), .res_valid_o(res_valid_o)
  );

  function automatic logic [31:0] val(input int i);
    case (i)
      0:  return 32'h0000_0000; // +0
      1:  return 32'h8000_0000; // -0
      2:  return 32'h3F80_0000; // 1.0
      3:  return 32'hBF80_0000; // -1.0
      4:  return 32'h4000_0000; // 2.0
      5:  return 32'hC020_0000; // -2.5
      6:  return 32'h7F80_0000; // +inf
      7:  return 32'hFF80_0000; // -inf
      8:  return 32'h7FC0_0000; // quiet NaN
      9:  return 32'hFF80_0001; // signalling NaN, negative
      10: return 32'h7F7F_FFFF; // max finite
      11: return 32'h0000_0001; // min denormal
      default: return 32'h8000_0001; // negative min denormal
    endcase
  endfunction

  // Real value of a lane; infinities map beyond the finite range.
  function automatic real fval(input logic [31:0] x, output bit nan);
    int  e;
    real v;
    e   = int'(x[30:23]);
    nan = (e == 255) && (x[22:0] != 0);
    if (e == 255)      v = 1.0e40;
    else if (e == 0)   v = real'(x[22:0]) * (2.0 ** (-149.0));
    else               v = real'({1'b1, x[22:0]}) * (2.0 ** (real'(e) - 150.0));
    if (x[31]) v = -v;
    return v;
  endfunction

  function automatic bit ref_hit(input logic [31:0] a, input logic [31:0] b, input int p);
    bit na, nb, un, eq, lt;
    real ra, rb;
    ra = fval(a, na);
    rb = fval(b, nb);
    un = na | nb;
    eq = !un && (ra == rb);
    lt = !un && (ra < rb);
    case (p)
      0: return eq;
      1: return lt;
      2: return lt | eq;
      3: return un;
      4: return !eq;
      5: return !lt;
      6: return !(lt | eq);
      default: return !un;
    endcase
  endfunction

  function automatic logic [127:0] ref_vec(input logic [127:0] d, input logic [127:0] s,
                                           input int p, input bit sc);
    logic [127:0] r;
    for (int k = 0; k < 4; k++) begin
      if (sc && k > 0) r[k*32 +: 32] = d[k*32 +: 32];
      else r[k*32 +: 32] = ref_hit(d[k*32 +: 32], s[k*32 +: 32], p) ? 32'hFFFF_FFFF : 32'h0;
    end
    return r;
  endfunction

  task automatic check(input bit ok, input string tag, input logic [127:0] act,
                       input logic [127:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // Drive one strobe at a falling edge, sample at the next falling edge.
  task automatic run_vec(input logic [127:0] d, input logic [127:0] s, input logic [7:0] imm,
                         input bit sc, input string tag);
    logic [127:0] exp;
    dst_i = d; src_i = s; imm_i = imm; scalar_i = sc; in_valid = 1'b1;
    exp = ref_vec(d, s, int'(imm[2:0]), sc);
    @(negedge clk);
    check(res_o == exp, tag, res_o, exp);
    check(res_valid_o == 1'b1, {tag, " R8 valid"}, {127'b0, res_valid_o}, 128'd1);
  endtask

  initial begin
    logic [127:0] d, s, held, exp_a;
    repeat (3) @(negedge clk);
    // R9: reset state
    check(res_o == '0, "R9 reset result", res_o, '0);
    check(res_valid_o == 1'b0, "R9 reset valid", {127'b0, res_valid_o}, '0);
    rst = 1'b0;
    @(negedge clk);

    // R1 R2 R3 R5 R6 R10: packed sweep over all value pairs and predicates
    for (int ia = 0; ia < NV; ia++)
      for (int ib = 0; ib < NV; ib++)
        for (int p = 0; p < 8; p++) begin
          for (int k = 0; k < 4; k++) begin
            d[k*32 +: 32] = val((ia + k) % NV);
            s[k*32 +: 32] = val((ib + 5 * k) % NV);
          end
          run_vec(d, s, {5'(ia * 3 + ib), 3'(p)}, 1'b0, "R1/R2/R3/R5/R6/R10 packed");
        end

    // R4: scalar sweep, upper destination lanes carry arbitrary patterns
    for (int ia = 0; ia < NV; ia++)
      for (int ib = 0; ib < NV; ib++)
        for (int p = 0; p < 8; p++) begin
          d = {32'(ia * 32'h0101_0101 + p), 32'hA5A5_0000 + 32'(ib), val(8), val(ia)};
          s = {val(ib), val(ia), val(7), val(ib)};
          run_vec(d, s, {5'b0, 3'(p)}, 1'b1, "R4 scalar");
        end

    // R7: upper immediate bits do not change the outcome
    d = {val(2), val(8), val(5), val(0)};
    s = {val(4), val(2), val(5), val(1)};
    run_vec(d, s, 8'b0000_0010, 1'b0, "R7 imm low");
    exp_a = res_o;
    run_vec(d, s, 8'b1111_1010, 1'b0, "R7 imm high");
    check(res_o == exp_a, "R7 upper bits ignored", res_o, exp_a);

    // R8: no strobe, inputs move, result holds and valid stays low
    in_valid = 1'b0;
    held = res_o;
    dst_i = '1; src_i = '0; imm_i = 8'h04;
    repeat (3) begin
      @(negedge clk);
      check(res_o == held, "R8 hold result", res_o, held);
      check(res_valid_o == 1'b0, "R8 valid low", {127'b0, res_valid_o}, '0);
    end

    // R9: reset wins over a strobe in the same cycle
    run_vec(d, s, 8'h05, 1'b0, "R9 pre-reset");
    rst = 1'b1; in_valid = 1'b1; imm_i = 8'h04;
    @(negedge clk);
    check(res_o == '0, "R9 reset over strobe", res_o, '0);
    check(res_valid_o == 1'b0, "R9 reset valid", {127'b0, res_valid_o}, '0);
    rst = 1'b0; in_valid = 1'b0;
    @(negedge clk);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(5.0 * 150000);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule